// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block turns an asynchronous serial line into bytes. A frame is a low start bit, seven or eight data bits sent least significant bit first, an optional parity bit, and one or two high stop bits. A built-in divider makes a tick at sixteen times the bit rate. The line passes through a two-flop synchronizer and is sampled at the middle of each bit.

Each completed frame is written to a receive data register. A clean frame raises a data-ready flag. A frame with a bad stop bit or bad parity raises a sticky error flag instead. While either error flag is set, the receiver accepts no new frame. Software clears an error flag in two steps: it reads the status while the flag is one, then writes zero to that flag. Reading the data register drops the data-ready flag.

Top module: `uart_rx_sticky`

## Requirements
- R1: After reset, rx_data_o is 0 and full_o, ferr_o and perr_o are all 0.
- R2: A frame starts on a falling edge of the idle-high line. Data bits arrive least significant bit first. With data8_i=1 there are 8 data bits; with data8_i=0 there are 7 and bit 7 of rx_data_o reads 0. A frame without error loads rx_data_o and sets full_o.
- R3: One oversampling tick happens every baud_div_i+1 clocks, and one bit lasts 16 ticks. If the line is high again at the middle of the start bit, the start is treated as noise and nothing is received.
- R4: When par_en_i=1, one parity bit follows the data. par_odd_i=0 selects even parity and par_odd_i=1 selects odd parity; the rule applies to the count of ones in the data bits plus the parity bit. A mismatch sets perr_o. When par_en_i=0, no parity bit is expected and perr_o is never set.
- R5: If the first stop bit is sampled as 0, ferr_o is set. When stop2_i=1, the second stop bit is not checked.
- R6: A frame with a framing or parity error still loads rx_data_o, but it does not set full_o.
- R7: While ferr_o or perr_o is 1, no new frame is received: rx_data_o and full_o do not change.
- R8: A pulse on rd_stat_i while a flag is 1 arms that flag. A pulse on wr_stat_i clears each armed flag whose bit in wr_val_i is 0 (bit 0 is the framing flag, bit 1 is the parity flag). Every write disarms both flags. A write without a prior arming read has no effect, and writing 1 has no effect.
- R9: While rx_en_i=0, no frame is received, and both error flags keep their values.
- R10: A pulse on rd_data_i clears full_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial line, idle high |
| rx_en_i | input | 1 | Receive enable |
| baud_div_i | input | DIV_W | Clocks per oversampling tick, minus one |
| data8_i | input | 1 | 1: eight data bits, 0: seven data bits |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| stop2_i | input | 1 | Two stop bits |
| rd_data_i | input | 1 | Data register read strobe |
| rd_stat_i | input | 1 | Status read strobe |
| wr_stat_i | input | 1 | Status write strobe |
| wr_val_i | input | 2 | Status write value: bit0 framing, bit1 parity |
| rx_data_o | output | 8 | Receive data register |
| full_o | output | 1 | Received data ready |
| ferr_o | output | 1 | Sticky framing error |
| perr_o | output | 1 | Sticky parity error |

## Verification
The result of a frame reaches the outputs one clock after the first stop bit is sampled. That sample is taken about half a bit, plus two synchronizer clocks, after the stop bit starts. The bench drives every stop bit in full and then holds the line idle for two bit times before it samples, so the result is already stable. A strobe on rd_data_i, rd_stat_i or wr_stat_i takes effect on the next rising edge. The bench drives each strobe for one cycle from a falling edge and reads the outputs at a later falling edge. Frames that the receiver must ignore are followed by the same idle wait, so a wrongly accepted frame would be visible when the bench checks.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_STOP2
  } rx_state_e;

  localparam int unsigned OVS   = 16;
  localparam int unsigned OVS_W = $clog2(OVS);
  localparam int unsigned MID   = OVS / 2 - 1;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NFLAG = 2;
endpackage

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_n;

  assign tick_o = (cnt_q == div_i);

  always_comb begin
    cnt_n = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_n;
  end

  // R3
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0) |=> !tick_o);
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              en_i,
  input  logic              block_i,
  input  logic              data8_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              stop2_i,
  output logic              done_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              ferr_o,
  output logic              perr_o
);
  rx_state_e         state_q, state_n;
  logic [OVS_W-1:0]  cnt_q, cnt_n;
  logic [2:0]        idx_q, idx_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic              par_q, par_n;
  logic              prev_q;
  logic              at_mid, at_end;
  logic [2:0]        last_idx;

  assign at_mid   = tick_i && (cnt_q == OVS_W'(MID));
  assign at_end   = tick_i && (cnt_q == '1);
  assign last_idx = data8_i ? 3'd7 : 3'd6;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    idx_n   = idx_q;
    sh_n    = sh_q;
    par_n   = par_q;
    done_o  = 1'b0;
    if (state_q != RX_IDLE && tick_i) cnt_n = cnt_q + 1'b1;
    case (state_q)
      RX_IDLE: begin
        cnt_n = '0;
        idx_n = '0;
        if (en_i && !block_i && prev_q && !rx_i) state_n = RX_START;
      end
      RX_START: begin
        if (at_mid) begin
          cnt_n   = '0;
          state_n = rx_i ? RX_IDLE : RX_DATA;
        end
      end
      RX_DATA: begin
        if (at_end) begin
          sh_n = {rx_i, sh_q[BYTE_W-1:1]};
          if (idx_q == last_idx) state_n = par_en_i ? RX_PAR : RX_STOP;
          else                   idx_n   = idx_q + 1'b1;
        end
      end
      RX_PAR: begin
        if (at_end) begin
          par_n   = rx_i;
          state_n = RX_STOP;
        end
      end
      RX_STOP: begin
        if (at_end) begin
          done_o  = en_i;
          state_n = stop2_i ? RX_STOP2 : RX_IDLE;
        end
      end
      RX_STOP2: begin
        if (at_end) state_n = RX_IDLE;
      end
      default: state_n = RX_IDLE;
    endcase
    if (!en_i) state_n = RX_IDLE;
  end

  assign data_o = data8_i ? sh_q : {1'b0, sh_q[BYTE_W-1:1]};
  assign ferr_o = done_o && !rx_i;
  assign perr_o = done_o && par_en_i && ((^data_o ^ par_q) != par_odd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      prev_q  <= 1'b1;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      idx_q   <= idx_n;
      sh_q    <= sh_n;
      par_q   <= par_n;
      prev_q  <= rx_i;
    end
  end

  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_IDLE && (block_i || !en_i)) |=> state_q == RX_IDLE);
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic [NFLAG-1:0]  evt_i,
  input  logic              rd_data_i,
  input  logic              rd_stat_i,
  input  logic              wr_stat_i,
  input  logic [NFLAG-1:0]  wr_val_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              full_o,
  output logic [NFLAG-1:0]  flag_o
);
  logic [BYTE_W-1:0] data_q, data_n;
  logic              full_q, full_n;
  logic [NFLAG-1:0]  flag_q, flag_n, arm_q, arm_n;

  always_comb begin
    data_n = done_i ? data_i : data_q;
    full_n = full_q;
    if (done_i && !(|evt_i)) full_n = 1'b1;
    else if (rd_data_i)      full_n = 1'b0;
    for (int i = 0; i < int'(NFLAG); i++) begin
      flag_n[i] = flag_q[i];
      arm_n[i]  = arm_q[i];
      if (wr_stat_i) begin
        if (!wr_val_i[i] && arm_q[i]) flag_n[i] = 1'b0;
        arm_n[i] = 1'b0;
      end else if (rd_stat_i && flag_q[i]) begin
        arm_n[i] = 1'b1;
      end
      if (done_i && evt_i[i]) flag_n[i] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
      flag_q <= '0;
      arm_q  <= '0;
    end else begin
      data_q <= data_n;
      full_q <= full_n;
      flag_q <= flag_n;
      arm_q  <= arm_n;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
  assign flag_o = flag_q;

  // R8
  ferr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q[0]) |-> $past(wr_stat_i && !wr_val_i[0] && arm_q[0]));
  // R8
  perr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q[1]) |-> $past(wr_stat_i && !wr_val_i[1] && arm_q[1]));
  // R6
  err_no_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && (|evt_i) && !full_q) |=> !full_q);
  // R10
  rd_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_i && !done_i) |=> !full_q);
endmodule

// File: rtl/uart_rx_sticky.sv
module uart_rx_sticky
  import uart_rx_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              rx_en_i,
  input  logic [DIV_W-1:0]  baud_div_i,
  input  logic              data8_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              stop2_i,
  input  logic              rd_data_i,
  input  logic              rd_stat_i,
  input  logic              wr_stat_i,
  input  logic [1:0]        wr_val_i,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              full_o,
  output logic              ferr_o,
  output logic              perr_o
);
  logic [1:0]        sync_q;
  logic              tick;
  logic              done;
  logic [BYTE_W-1:0] fr_data;
  logic              fr_ferr, fr_perr;
  logic [NFLAG-1:0]  flags;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rx_i};
  end

  uart_rx_baud #(.DIV_W(DIV_W)) baud_i (
    .clk_i (clk_i), .rst_ni (rst_ni), .div_i (baud_div_i), .tick_o (tick)
  );

  uart_rx_frame frame_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .rx_i      (sync_q[1]),
    .en_i      (rx_en_i),
    .block_i   (|flags),
    .data8_i   (data8_i),
    .par_en_i  (par_en_i),
    .par_odd_i (par_odd_i),
    .stop2_i   (stop2_i),
    .done_o    (done),
    .data_o    (fr_data),
    .ferr_o    (fr_ferr),
    .perr_o    (fr_perr)
  );

  uart_rx_status status_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (done),
    .data_i    (fr_data),
    .evt_i     ({fr_perr, fr_ferr}),
    .rd_data_i (rd_data_i),
    .rd_stat_i (rd_stat_i),
    .wr_stat_i (wr_stat_i),
    .wr_val_i  (wr_val_i),
    .data_o    (rx_data_o),
    .full_o    (full_o),
    .flag_o    (flags)
  );

  assign ferr_o = flags[0];
  assign perr_o = flags[1];

  // R4
  perr_needs_par_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(perr_o) |-> $past(par_en_i));
endmodule

// File: tb/uart_rx_sticky_tb_top.sv
module uart_rx_sticky_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 3;
  localparam int BIT        = 16 * (DIV + 1);
  localparam int LIMIT      = 150000;

  logic       clk, rst_n, rx, rx_en, data8, par_en, par_odd, stop2;
  logic       rd_data, rd_stat, wr_stat;
  logic [1:0] wr_val;
  logic [7:0] rx_data;
  logic       full, ferr, perr;
  int         total, bad;
  bit         finished;

  uart_rx_sticky #(.DIV_W(8)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .rx_i (rx), .rx_en_i (rx_en),
    .baud_div_i (8'(DIV)), .data8_i (data8), .par_en_i (par_en),
    .par_odd_i (par_odd), .stop2_i (stop2), .rd_data_i (rd_data),
    .rd_stat_i (rd_stat), .wr_stat_i (wr_stat), .wr_val_i (wr_val),
    .rx_data_o (rx_data), .full_o (full), .ferr_o (ferr), .perr_o (perr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] exp_data(input logic [7:0] d, input bit d8);
    return d8 ? d : {1'b0, d[6:0]};
  endfunction

  function automatic logic good_par(input logic [7:0] d, input bit d8, input bit odd);
    return (^exp_data(d, d8)) ^ odd;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v);
    rx = v;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit bad_par,
                      input logic s1, input logic s2v);
    drive_bit(1'b0);
    for (int i = 0; i < (data8 ? 8 : 7); i++) drive_bit(d[i]);
    if (par_en) drive_bit(good_par(d, data8, par_odd) ^ bad_par);
    drive_bit(s1);
    if (stop2) drive_bit(s2v);
    rx = 1'b1;
    repeat (2 * BIT) @(negedge clk);
  endtask

  task automatic pulse_rd;
    rd_data = 1'b1; @(negedge clk); rd_data = 1'b0; @(negedge clk);
  endtask

  task automatic rd_status;
    rd_stat = 1'b1; @(negedge clk); rd_stat = 1'b0; @(negedge clk);
  endtask

  task automatic wr_status(input logic [1:0] v);
    wr_val = v; wr_stat = 1'b1; @(negedge clk); wr_stat = 1'b0; @(negedge clk);
  endtask

  task automatic cfg(input bit d8, input bit pe, input bit po, input bit s2);
    data8 = d8; par_en = pe; par_odd = po; stop2 = s2;
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; finished = 0;
    void'($urandom(32'd2024));
    rst_n = 1'b0; rx = 1'b1; rx_en = 1'b1;
    rd_data = 0; rd_stat = 0; wr_stat = 0; wr_val = 2'b00;
    cfg(1, 0, 0, 0);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 data", rx_data, 0); chk("R1 full", full, 0);
    chk("R1 ferr", ferr, 0);    chk("R1 perr", perr, 0);

    rx = 1'b0; repeat (16) @(negedge clk); rx = 1'b1;
    repeat (3 * BIT) @(negedge clk);
    chk("R3 noise start", full, 0);

    send(8'hA5, 0, 1, 1);
    chk("R2 data 8N1", rx_data, 8'hA5); chk("R2 full", full, 1);
    pulse_rd;
    chk("R10 full cleared", full, 0); chk("R10 data kept", rx_data, 8'hA5);

    cfg(0, 0, 0, 0);
    send(8'hFF, 0, 1, 1);
    chk("R2 seven bit", rx_data, 8'h7F);
    pulse_rd;

    cfg(1, 1, 0, 0);
    send(8'h3C, 1, 1, 1);
    chk("R4 perr set", perr, 1); chk("R6 data loaded", rx_data, 8'h3C);
    chk("R6 no full", full, 0);  chk("R4 no ferr", ferr, 0);

    cfg(1, 0, 0, 0);
    send(8'h11, 0, 1, 1);
    chk("R7 blocked data", rx_data, 8'h3C); chk("R7 blocked full", full, 0);

    wr_status(2'b00);
    chk("R8 write without read", perr, 1);
    rx_en = 1'b0; repeat (20) @(negedge clk);
    chk("R9 flag kept", perr, 1);
    rx_en = 1'b1; @(negedge clk);
    rd_status; wr_status(2'b10);
    chk("R8 write one", perr, 1);
    rd_status; wr_status(2'b00);
    chk("R8 cleared", perr, 0);

    cfg(1, 1, 1, 0);
    send(8'h07, 0, 1, 1);
    chk("R4 odd ok full", full, 1); chk("R4 odd ok perr", perr, 0);
    chk("R4 odd data", rx_data, 8'h07);
    pulse_rd;

    cfg(1, 0, 0, 1);
    send(8'h5A, 0, 0, 1);
    chk("R5 ferr set", ferr, 1); chk("R6 ferr data", rx_data, 8'h5A);
    chk("R6 ferr no full", full, 0);
    rd_status; wr_status(2'b00);
    chk("R8 ferr cleared", ferr, 0);

    send(8'hC3, 0, 1, 0);
    chk("R5 second stop ignored", ferr, 0); chk("R5 full", full, 1);
    chk("R5 data", rx_data, 8'hC3);
    pulse_rd;

    rx_en = 1'b0;
    send(8'h99, 0, 1, 1);
    chk("R9 disabled", full, 0);
    rx_en = 1'b1; @(negedge clk);

    for (int n = 0; n < 30; n++) begin
      logic [7:0] d;
      int         e;
      bit         ep, ef;
      logic       s2v;
      cfg($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2);
      d   = 8'($urandom);
      e   = $urandom % 4;
      s2v = 1'($urandom);
      ef  = (e == 2);
      ep  = (e == 3) && par_en;
      send(d, ep, !ef, s2v);
      chk("R2 rand data", rx_data, exp_data(d, data8));
      chk("R6 rand full", full, !(ef || ep));
      chk("R5 rand ferr", ferr, ef);
      chk("R4 rand perr", perr, ep);
      if (full) pulse_rd;
      if (ferr || perr) begin rd_status; wr_status(2'b00); end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule